// File: doc/BRIEF.md
# Three-Tap Reduced-Multiplier Sliding Filter Core

This core evaluates three neighbouring outputs of a three-tap FIR filter in one step. A window of five consecutive signed samples comes in, and three dot products come out. Each dot product pairs the three taps with a window shifted by one sample, so output j is the sum over tap i of sample(i+j) times w(i). A direct evaluation needs nine multipliers. This core needs six. It folds pairs of taps into six scale factors and combines the samples into six matching terms. It multiplies each factor by its term and then adds the six products back together, three at a time, to form the outputs.

The tap values are held in a small coefficient bank. A one-cycle load strobe writes them, and the bank also stores the derived scale factors, so the sum logic is out of the sample path. The products and their sums are kept at full precision. Each result is then clipped to the signed output width. With the output register enabled, which is the default, a valid flag follows each accepted window by one cycle. A larger convolution engine uses this core as its inner kernel. It feeds the core one window per cycle, and each window advances by three samples.

Top module: `hk3_filter`

## Requirements
- R1: With coefficients w0..w2 loaded, a window accepted with `in_vld` high gives, one cycle later, y0 = x0w0+x1w1+x2w2, y1 = x1w0+x2w1+x3w2 and y2 = x2w0+x3w1+x4w2. All values are signed two's complement. Sample k is `x_in[8k+7:8k]`, tap i is `coef_in[8i+7:8i]`, and output j is `y_out[16j+15:16j]`.
- R2: A result above 32767 appears as 32767, and a result below -32768 appears as -32768.
- R3: `coef_in` is captured only at a rising clock edge where `coef_ld` is high. While `coef_ld` is low, changes on `coef_in` do not affect the outputs.
- R4: `out_vld` is high in the cycle after a cycle in which `in_vld` is high, and low in the cycle after a cycle in which `in_vld` is low.
- R5: While `in_vld` is low, `y_out` keeps its last value, even if `x_in` changes.
- R6: Reset, active low, clears `out_vld`, `y_out` and all stored coefficients. Windows accepted before any load therefore produce zero.
- R7: Results are exact across the full sample and tap ranges. Extreme values such as -128 and 127, mixed within one window, give the exact dot product with no wrap inside the core.
- R8: A window accepted in the same cycle as a coefficient load uses the previously stored coefficients. The next window uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_ld | input | 1 | Strobe that writes the coefficient bank |
| coef_in | input | 24 | Three signed 8-bit taps, tap 0 in the low byte |
| in_vld | input | 1 | Window valid |
| x_in | input | 40 | Five signed 8-bit samples, sample 0 in the low byte |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| y_out | output | 48 | Three signed 16-bit results, output 0 in the low half-word |

## Verification
On every cycle the assertions check three things: the one-cycle valid timing, that outputs hold while no window is accepted, and that each registered result matches a direct nine-product reference. That reference is built from its own copy of the loaded taps and is clipped the same way. The bench scenarios cover what a single-cycle relation cannot show. These are the cleared coefficients after reset, and the saturation points at both ends. They also include windows that drive the sample differences to their extreme values, a strobe-less change of `coef_in`, and the ordering when a load and a window arrive in the same cycle.

// File: rtl/hk3_pkg.sv
package hk3_pkg;
    localparam int TAPS = 3;
    localparam int WIN  = 2 * TAPS - 1;
    localparam int NFAC = 6;

    // scale factor slots; the same index selects the matching sample term
    localparam int FI_W0  = 0;
    localparam int FI_W01 = 1;
    localparam int FI_W1  = 2;
    localparam int FI_W02 = 3;
    localparam int FI_W12 = 4;
    localparam int FI_W2  = 5;
endpackage

// File: rtl/hk3_coef_bank.sv
module hk3_coef_bank
    import hk3_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld,
    input  logic [TAPS*CW-1:0]       coef_in,
    output logic [NFAC*(CW+1)-1:0]   fac_out
);
    localparam int FW = CW + 1;

    typedef struct packed {
        logic [NFAC-1:0][FW-1:0] fac;
    } bank_t;

    bank_t st_d, st_q;
    logic signed [FW-1:0] w [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign w[i] = FW'($signed(coef_in[i*CW +: CW]));
    end

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.fac[FI_W0]  = w[0];
            st_d.fac[FI_W01] = w[0] + w[1];
            st_d.fac[FI_W1]  = w[1];
            st_d.fac[FI_W02] = w[0] + w[2];
            st_d.fac[FI_W12] = w[1] + w[2];
            st_d.fac[FI_W2]  = w[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fac_out = st_q.fac;
endmodule

// File: rtl/hk3_pre_add.sv
module hk3_pre_add
    import hk3_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic [WIN*SW-1:0]       x_in,
    output logic [NFAC*(SW+2)-1:0]  term_out
);
    localparam int TW = SW + 2;

    logic signed [TW-1:0] xs [WIN];
    logic signed [TW-1:0] t  [NFAC];

    for (genvar k = 0; k < WIN; k++) begin : g_ext
        assign xs[k] = TW'($signed(x_in[k*SW +: SW]));
    end

    always_comb begin
        t[FI_W0]  = xs[0] - xs[1] - xs[2];
        t[FI_W01] = xs[1];
        t[FI_W1]  = xs[2] - xs[1] - xs[3];
        t[FI_W02] = xs[2];
        t[FI_W12] = xs[3];
        t[FI_W2]  = xs[4] - xs[2] - xs[3];
    end

    for (genvar f = 0; f < NFAC; f++) begin : g_pack
        assign term_out[f*TW +: TW] = t[f];
    end
endmodule

// File: rtl/hk3_mul_net.sv
module hk3_mul_net
    import hk3_pkg::*;
#(
    parameter int SW = 8,
    parameter int CW = 8
) (
    input  logic [NFAC*(CW+1)-1:0]      fac_in,
    input  logic [NFAC*(SW+2)-1:0]      term_in,
    output logic [TAPS*(CW+SW+5)-1:0]   sum_out
);
    localparam int FW = CW + 1;
    localparam int TW = SW + 2;
    localparam int PW = FW + TW;
    localparam int AW = PW + 2;

    logic signed [PW-1:0] p [NFAC];
    logic signed [AW-1:0] s [TAPS];

    for (genvar f = 0; f < NFAC; f++) begin : g_mul
        logic signed [FW-1:0] fv;
        logic signed [TW-1:0] tv;
        assign fv   = $signed(fac_in[f*FW +: FW]);
        assign tv   = $signed(term_in[f*TW +: TW]);
        assign p[f] = PW'(fv) * PW'(tv);
    end

    always_comb begin
        s[0] = AW'(p[FI_W01]) + AW'(p[FI_W02]) + AW'(p[FI_W0]);
        s[1] = AW'(p[FI_W01]) + AW'(p[FI_W12]) + AW'(p[FI_W1]);
        s[2] = AW'(p[FI_W02]) + AW'(p[FI_W12]) + AW'(p[FI_W2]);
    end

    for (genvar j = 0; j < TAPS; j++) begin : g_out
        assign sum_out[j*AW +: AW] = s[j];
    end
endmodule

// File: rtl/hk3_sat.sv
module hk3_sat
    import hk3_pkg::*;
#(
    parameter int AW = 21,
    parameter int OW = 16
) (
    input  logic [TAPS*AW-1:0] sum_in,
    output logic [TAPS*OW-1:0] y_out
);
    localparam logic signed [AW-1:0] HI = AW'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [AW-1:0] LO = -HI - AW'(1);

    for (genvar j = 0; j < TAPS; j++) begin : g_lane
        logic signed [AW-1:0] v;
        assign v = $signed(sum_in[j*AW +: AW]);
        always_comb begin
            if (v > HI)      y_out[j*OW +: OW] = HI[OW-1:0];
            else if (v < LO) y_out[j*OW +: OW] = LO[OW-1:0];
            else             y_out[j*OW +: OW] = v[OW-1:0];
        end
    end
endmodule

// File: rtl/hk3_filter.sv
module hk3_filter
    import hk3_pkg::*;
#(
    parameter int SW   = 8,
    parameter int CW   = 8,
    parameter int OW   = 16,
    parameter bit PIPE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coef_ld,
    input  logic [TAPS*CW-1:0] coef_in,
    input  logic               in_vld,
    input  logic [WIN*SW-1:0]  x_in,
    output logic               out_vld,
    output logic [TAPS*OW-1:0] y_out
);
    localparam int FW = CW + 1;
    localparam int TW = SW + 2;
    localparam int AW = CW + SW + 5;

    logic [NFAC*FW-1:0]  fac;
    logic [NFAC*TW-1:0]  term;
    logic [TAPS*AW-1:0]  sum;
    logic [TAPS*OW-1:0]  y_sat;

    hk3_coef_bank #(.CW(CW)) u_bank (
        .clk(clk), .rst_n(rst_n), .ld(coef_ld), .coef_in(coef_in), .fac_out(fac)
    );

    hk3_pre_add #(.SW(SW)) u_pre (
        .x_in(x_in), .term_out(term)
    );

    hk3_mul_net #(.SW(SW), .CW(CW)) u_mul (
        .fac_in(fac), .term_in(term), .sum_out(sum)
    );

    hk3_sat #(.AW(AW), .OW(OW)) u_sat (
        .sum_in(sum), .y_out(y_sat)
    );

    if (PIPE) begin : g_reg
        typedef struct packed {
            logic               vld;
            logic [TAPS*OW-1:0] y;
        } out_t;

        out_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_vld;
            if (in_vld) st_d.y = y_sat;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign out_vld = st_q.vld;
        assign y_out   = st_q.y;
    end else begin : g_comb
        assign out_vld = in_vld;
        assign y_out   = y_sat;
    end
endmodule

// File: rtl/hk3_chk.sv
module hk3_chk
    import hk3_pkg::*;
#(
    parameter int SW   = 8,
    parameter int CW   = 8,
    parameter int OW   = 16,
    parameter bit PIPE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               coef_ld,
    input logic [TAPS*CW-1:0] coef_in,
    input logic               in_vld,
    input logic [WIN*SW-1:0]  x_in,
    input logic               out_vld,
    input logic [TAPS*OW-1:0] y_out
);
    logic [TAPS*CW-1:0] ck_w;
    logic [TAPS*OW-1:0] ref_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ck_w <= '0;
        else if (coef_ld) ck_w <= coef_in;
    end

    function automatic logic [OW-1:0] clip(input longint v);
        longint hi;
        hi = (longint'(1) <<< (OW - 1)) - 1;
        if (v > hi)        return OW'(hi);
        else if (v < -hi-1) return OW'(-hi - 1);
        else               return OW'(v);
    endfunction

    always_comb begin
        for (int j = 0; j < TAPS; j++) begin
            longint acc;
            acc = 0;
            for (int i = 0; i < TAPS; i++)
                acc += longint'($signed(x_in[(i+j)*SW +: SW])) *
                       longint'($signed(ck_w[i*CW +: CW]));
            ref_y[j*OW +: OW] = clip(acc);
        end
    end

    if (PIPE) begin : g_props
        // R4
        vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> out_vld);
        // R4
        vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> !out_vld);
        // R5
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> $stable(y_out));
        // R1 R2 R7 R8
        direct_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> (y_out == $past(ref_y)));
    end
endmodule

bind hk3_filter hk3_chk #(.SW(SW), .CW(CW), .OW(OW), .PIPE(PIPE)) u_chk (.*);

// File: tb/sim_hk3_filter.sv
module sim_hk3_filter;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int CW = 8;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_ld = 1'b0;
    logic [23:0]   coef_in = '0;
    logic          in_vld = 1'b0;
    logic [39:0]   x_in = '0;
    logic          out_vld;
    logic [47:0]   y_out;

    int errs = 0;
    int checks = 0;
    int tb_w [3] = '{0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    hk3_filter #(.SW(SW), .CW(CW), .OW(OW), .PIPE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .coef_ld(coef_ld), .coef_in(coef_in),
        .in_vld(in_vld), .x_in(x_in), .out_vld(out_vld), .y_out(y_out)
    );

    function automatic longint clip16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint expect_lane(input int xs[5], input int w[3], input int j);
        longint acc = 0;
        for (int i = 0; i < 3; i++) acc += longint'(xs[i+j]) * longint'(w[i]);
        return clip16(acc);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint lane(input int j);
        return longint'($signed(y_out[j*16 +: 16]));
    endfunction

    task automatic drive_x(input int xs[5]);
        for (int i = 0; i < 5; i++) x_in[i*8 +: 8] = xs[i][7:0];
    endtask

    task automatic load_coef(input int w0, input int w1, input int w2);
        coef_in = {w2[7:0], w1[7:0], w0[7:0]};
        coef_ld = 1'b1;
        @(negedge clk);
        coef_ld = 1'b0;
        tb_w = '{w0, w1, w2};
    endtask

    // accept one window, check result one cycle later against tb_w
    task automatic push(input string tag, input int xs[5]);
        drive_x(xs);
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check({tag, " R4 out_vld"}, longint'(out_vld), 1);
        for (int j = 0; j < 3; j++)
            check(tag, lane(j), expect_lane(xs, tb_w, j));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R6 reset out_vld", longint'(out_vld), 0);
        check("R6 reset y_out", longint'(y_out == '0), 1);
        rst_n = 1'b1;
        @(negedge clk);
        push("R6 zero coefficients", '{5, 6, 7, 8, 9});
    endtask

    task automatic t_basic();
        load_coef(1, 2, 3);
        push("R1 ramp", '{1, 2, 3, 4, 5});
        load_coef(-3, 7, -11);
        push("R1 mixed signs", '{-9, 4, 0, 13, -2});
        push("R1 alternating", '{100, -100, 100, -100, 100});
        push("R1 zero window", '{0, 0, 0, 0, 0});
    endtask

    task automatic t_guard();
        load_coef(127, -128, 127);
        push("R7 extreme diffs", '{-128, 127, 127, 127, -128});
        load_coef(-128, -128, 127);
        push("R7 extreme diffs b", '{127, -128, -128, -128, 127});
    endtask

    task automatic t_sat();
        load_coef(-128, -128, -128);
        push("R2 positive clip", '{-128, -128, -128, -128, -128});
        load_coef(127, 127, 127);
        push("R2 negative clip", '{-128, -128, -128, -128, -128});
    endtask

    task automatic t_hold();
        logic [47:0] snap;
        load_coef(2, -1, 5);
        push("R5 setup", '{3, 1, 4, 1, 5});
        snap = y_out;
        drive_x('{90, -90, 45, 12, -7});
        repeat (3) begin
            @(negedge clk);
            check("R4 idle out_vld", longint'(out_vld), 0);
            check("R5 hold y_out", longint'(y_out == snap), 1);
        end
    endtask

    task automatic t_ignore();
        load_coef(4, 5, 6);
        coef_in = {8'd99, 8'd88, 8'd77};
        @(negedge clk);
        push("R3 coef_in without strobe", '{1, -2, 3, -4, 5});
    endtask

    task automatic t_same_cycle();
        int xs [5] = '{10, 20, 30, 40, 50};
        int old_w [3];
        load_coef(1, 1, 1);
        old_w = tb_w;
        coef_in = {8'd3, 8'hFE, 8'd9};
        coef_ld = 1'b1;
        drive_x(xs);
        in_vld = 1'b1;
        @(negedge clk);
        coef_ld = 1'b0;
        in_vld  = 1'b0;
        for (int j = 0; j < 3; j++)
            check("R8 same-cycle old taps", lane(j), expect_lane(xs, old_w, j));
        tb_w = '{9, -2, 3};
        push("R8 next window new taps", xs);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_guard();
        t_sat();
        t_hold();
        t_ignore();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule